// File: doc/BRIEF.md
# Memory Type Range Lookup

This block maps a physical address to the caching memory type that governs it. Two kinds of range description are held in registers. A single 64-bit fixed-range register splits the 128 KB legacy window from 0xA0000 to 0xBFFFF into eight 16 KB slices, and each slice has its own 8-bit type field. A bank of variable ranges, each a base/mask register pair with a valid bit, can describe any aligned physical region. A default-type register supplies the answer for any address that no range claims.

Software, or a configuration engine, loads every register through one indexed write port. The lookup path compares the address against all ranges in parallel and resolves overlaps with a fixed precedence. The result is a normalised type code: uncacheable, write-through or write-back. The default build registers the result, so the code for an address presented before a rising edge appears after that edge. A parameter selects a purely combinational path instead.

Top module: `memtype_lookup`

## Requirements
- R1: After reset every register reads as zero, so all variable ranges are invalid, the fixed fields and the default type are uncacheable, and every lookup returns 0.
- R2: For an address in 0xA0000..0xBFFFF the type is taken from bits 8k+7:8k of the fixed register, where k = addr[16:14]. Slice k=0 starts at 0xA0000 and slice k=7 ends at 0xBFFFF.
- R3: Inside 0xA0000..0xBFFFF the fixed register wins over every variable range. Addresses just outside that window (0x9FFFF, 0xC0000) do not use it.
- R4: Variable pair p matches when mask bit 11 (valid) is 1 and (addr & mask) == (base & mask) over bits 35:12. Its type is base bits 7:0. An invalid pair never matches.
- R5: When several variable ranges match, uncacheable (0) wins over write-through (4), and write-through wins over write-back (6).
- R6: When neither the fixed window nor any valid variable range matches, the type is bits 7:0 of the default-type register.
- R7: Type codes are 0 = uncacheable, 4 = write-through and 6 = write-back. Any other stored code yields 0, and the output never carries a value outside {0, 4, 6}.
- R8: A write takes effect only when wr_en is 1. wr_sel = 0 selects a variable register: wr_idx[3:1] is the pair, and wr_idx[0] is 0 for the base register and 1 for the mask register. wr_sel = 1 selects the fixed register, wr_sel = 2 selects the default type, and wr_sel = 3 changes nothing.
- R9: In the default registered build, lk_type reflects the lk_addr and register contents sampled at the previous rising edge, and it holds its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 variable, 1 fixed, 2 default, 3 none |
| wr_idx | input | 4 | Variable register index: pair in bits 3:1, mask/base in bit 0 |
| wr_data | input | 64 | Write data |
| lk_addr | input | 36 | Physical address to classify |
| lk_type | output | 8 | Resolved memory type code |

## Verification
The bench aims at the legacy window edges (0x9FFFF, 0xA0000, 0xA3FFF/0xA4000, 0xBFFFF, 0xC0000). A design with an off-by-one window or slice decode would return the default type, or the type of the neighbouring slice. It builds three overlapping variable ranges of different types and then takes them away one at a time; an inverted priority would return write-back where uncacheable is due. It stores illegal codes, clears valid bits, and issues writes with wr_sel = 3 or with wr_en low. A design that leaked raw codes, matched invalid pairs or accepted ignored writes would report a type that differs from the model's. Random stimulus from a fixed seed then mixes nested masks and reprogramming against a bench reference model.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
   localparam logic [7:0] MT_UC = 8'd0;
   localparam logic [7:0] MT_WT = 8'd4;
   localparam logic [7:0] MT_WB = 8'd6;

   // Legacy window 0xA0000..0xBFFFF is 128 KB aligned block number 5
   localparam int unsigned LEGACY_BLK   = 5;
   localparam int unsigned LEGACY_SHIFT = 17;
   localparam int unsigned SLICE_SHIFT  = 14;
   localparam int unsigned SLICE_CNT    = 8;
   localparam int unsigned FIELD_W      = 8;
   localparam int unsigned PAGE_LSB     = 12;
   localparam int unsigned VALID_BIT    = 11;

   typedef enum logic [1:0] {
      SEL_VAR  = 2'd0,
      SEL_FIX  = 2'd1,
      SEL_DEF  = 2'd2,
      SEL_NONE = 2'd3
   } wr_target_e;

   function automatic logic [7:0] mt_norm(input logic [7:0] code);
      if (code == MT_WT || code == MT_WB) return code;
      return MT_UC;
   endfunction
endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
   import memtype_pkg::*;
#(
   parameter int unsigned NUM_VAR = 8,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned REG_W   = 64
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [1:0]                        wr_sel,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [REG_W-1:0]                  wr_data,
   output logic [REG_W-1:0]                  fixed_q,
   output logic [FIELD_W-1:0]                def_q,
   output logic [NUM_VAR-1:0][REG_W-1:0]     base_q,
   output logic [NUM_VAR-1:0][REG_W-1:0]     mask_q
);
   localparam int unsigned PAIR_W = IDX_W - 1;

   if ((2 ** PAIR_W) < NUM_VAR) begin : g_bad_idx
      $error("mtr_regfile: IDX_W too narrow for NUM_VAR");
   end
   if (REG_W < SLICE_CNT * FIELD_W) begin : g_bad_reg
      $error("mtr_regfile: REG_W cannot hold the fixed slices");
   end

   wire            var_wr = wr_en && (wr_sel == SEL_VAR);
   wire [PAIR_W-1:0] pair = wr_idx[IDX_W-1:1];

   always_ff @(posedge clk) begin
      if (rst) begin
         fixed_q <= '0;
         def_q   <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_FIX) fixed_q <= wr_data;
         if (wr_sel == SEL_DEF) def_q   <= wr_data[FIELD_W-1:0];
      end
   end

   for (genvar p = 0; p < NUM_VAR; p++) begin : g_pair
      wire hit_p = var_wr && (pair == PAIR_W'(p));
      always_ff @(posedge clk) begin
         if (rst) begin
            base_q[p] <= '0;
            mask_q[p] <= '0;
         end else if (hit_p) begin
            if (wr_idx[0]) mask_q[p] <= wr_data;
            else           base_q[p] <= wr_data;
         end
      end
   end

   // R8: the spare target leaves stored state untouched
   p_sel_none_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(fixed_q) && $stable(def_q)
                                         && $stable(base_q) && $stable(mask_q)));
   p_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      (!wr_en) |=> ($stable(fixed_q) && $stable(def_q)
                    && $stable(base_q) && $stable(mask_q)));
endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match
   import memtype_pkg::*;
#(
   parameter int unsigned PA_W  = 36,
   parameter int unsigned REG_W = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PA_W-1:0]    addr,
   input  logic [REG_W-1:0]   base,
   input  logic [REG_W-1:0]   mask,
   output logic               hit,
   output logic [7:0]         mtype
);
   localparam int unsigned FLD_W = PA_W - PAGE_LSB;

   logic [FLD_W-1:0] a_f, b_f, m_f;
   logic             valid;

   always_comb begin
      a_f   = addr[PA_W-1:PAGE_LSB];
      b_f   = base[PA_W-1:PAGE_LSB];
      m_f   = mask[PA_W-1:PAGE_LSB];
      valid = mask[VALID_BIT];
      hit   = valid && (((a_f ^ b_f) & m_f) == '0);
      mtype = mt_norm(base[FIELD_W-1:0]);
   end

   // R4: a pair whose valid bit is clear never claims an address
   p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (!mask[VALID_BIT]) |-> !hit);
endmodule

// File: rtl/mtr_resolve.sv
module mtr_resolve
   import memtype_pkg::*;
#(
   parameter int unsigned NUM_VAR = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        legacy,
   input  logic [7:0]                  fixed_type,
   input  logic [NUM_VAR-1:0]          hit,
   input  logic [NUM_VAR-1:0][7:0]     vtype,
   input  logic [7:0]                  def_type,
   output logic [7:0]                  res
);
   logic [NUM_VAR-1:0] uc_v, wt_v, wb_v;

   for (genvar p = 0; p < NUM_VAR; p++) begin : g_cls
      assign uc_v[p] = hit[p] && (vtype[p] == MT_UC);
      assign wt_v[p] = hit[p] && (vtype[p] == MT_WT);
      assign wb_v[p] = hit[p] && (vtype[p] == MT_WB);
   end

   always_comb begin
      if (legacy)        res = fixed_type;
      else if (|uc_v)    res = MT_UC;
      else if (|wt_v)    res = MT_WT;
      else if (|wb_v)    res = MT_WB;
      else               res = mt_norm(def_type);
   end

   // R5: any uncacheable hit outside the window forces uncacheable
   p_uc_dominates_r5: assert property (@(posedge clk) disable iff (rst)
      (!legacy && (|hit) && (|uc_v)) |-> (res == MT_UC));
   // R6: with no claim at all the default register decides
   p_default_path_r6: assert property (@(posedge clk) disable iff (rst)
      (!legacy && hit == '0) |-> (res == mt_norm(def_type)));
endmodule

// File: rtl/memtype_lookup.sv
module memtype_lookup
   import memtype_pkg::*;
#(
   parameter int unsigned PA_W       = 36,
   parameter int unsigned NUM_VAR    = 8,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned REG_W      = 64,
   parameter bit          LOOKUP_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [PA_W-1:0]    lk_addr,
   output logic [7:0]         lk_type
);
   localparam int unsigned HI_W = PA_W - LEGACY_SHIFT;

   if (PA_W <= LEGACY_SHIFT + 2 || PA_W > REG_W - 1) begin : g_bad_pa
      $error("memtype_lookup: PA_W out of range");
   end

   logic [REG_W-1:0]              fixed_q;
   logic [FIELD_W-1:0]            def_q;
   logic [NUM_VAR-1:0][REG_W-1:0] base_q, mask_q;
   logic [NUM_VAR-1:0]            hit;
   logic [NUM_VAR-1:0][7:0]       vtype;
   logic                          legacy;
   logic [2:0]                    slice;
   logic [7:0]                    fixed_type;
   logic [7:0]                    res;

   mtr_regfile #(.NUM_VAR(NUM_VAR), .IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .fixed_q(fixed_q), .def_q(def_q),
      .base_q(base_q), .mask_q(mask_q)
   );

   for (genvar p = 0; p < NUM_VAR; p++) begin : g_cmp
      mtr_var_match #(.PA_W(PA_W), .REG_W(REG_W)) u_cmp (
         .clk(clk), .rst(rst), .addr(lk_addr), .base(base_q[p]),
         .mask(mask_q[p]), .hit(hit[p]), .mtype(vtype[p])
      );
   end

   always_comb begin
      legacy     = (lk_addr[PA_W-1:LEGACY_SHIFT] == HI_W'(LEGACY_BLK));
      slice      = lk_addr[LEGACY_SHIFT-1:SLICE_SHIFT];
      fixed_type = mt_norm(fixed_q[slice*FIELD_W +: FIELD_W]);
   end

   mtr_resolve #(.NUM_VAR(NUM_VAR)) u_res (
      .clk(clk), .rst(rst), .legacy(legacy), .fixed_type(fixed_type),
      .hit(hit), .vtype(vtype), .def_type(def_q), .res(res)
   );

   if (LOOKUP_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) lk_type <= MT_UC;
         else     lk_type <= res;
      end
   end else begin : g_comb
      assign lk_type = res;
   end

   // R7: only the three legal codes leave the block
   p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
      (lk_type == MT_UC) || (lk_type == MT_WT) || (lk_type == MT_WB));
endmodule

// File: tb/sim_memtype_lookup.sv
`timescale 1ns/1ps
module sim_memtype_lookup;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [3:0]  wr_idx;
   logic [63:0] wr_data;
   logic [35:0] lk_addr;
   logic [7:0]  lk_type;

   always #4 clk = ~clk;   // 125 MHz

   memtype_lookup u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .lk_addr(lk_addr), .lk_type(lk_type)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [63:0] m_fix, m_base[8], m_mask[8];
   logic [7:0]  m_def;

   function automatic logic [7:0] nrm(input logic [7:0] c);
      return (c == 8'd4 || c == 8'd6) ? c : 8'd0;
   endfunction

   function automatic logic [7:0] model(input logic [35:0] a);
      bit uc = 0, wt = 0, wb = 0;
      if (a[35:17] == 19'd5) return nrm(m_fix[a[16:14]*8 +: 8]);
      for (int p = 0; p < 8; p++) begin
         if (m_mask[p][11] &&
             (((a[35:12] ^ m_base[p][35:12]) & m_mask[p][35:12]) == 24'd0)) begin
            case (nrm(m_base[p][7:0]))
               8'd0: uc = 1;
               8'd4: wt = 1;
               default: wb = 1;
            endcase
         end
      end
      if (uc) return 8'd0;
      if (wt) return 8'd4;
      if (wb) return 8'd6;
      return nrm(m_def);
   endfunction

   task automatic wr(input logic [1:0] s, input logic [3:0] i,
                     input logic [63:0] d, input bit en);
      @(negedge clk);
      wr_en = en; wr_sel = s; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (en) begin
         case (s)
            2'd0: if (i[0]) m_mask[i[3:1]] = d; else m_base[i[3:1]] = d;
            2'd1: m_fix = d;
            2'd2: m_def = d[7:0];
            default: ;
         endcase
      end
   endtask

   task automatic chk(input logic [35:0] a, input string req);
      logic [7:0] e;
      @(negedge clk);
      lk_addr = a;
      @(negedge clk);
      e = model(a);
      checks++;
      if (lk_type !== e) begin
         fails++;
         $display("FAIL %s addr=%h actual=%0d expected=%0d", req, a, lk_type, e);
      end
   endtask

   function automatic logic [63:0] vbase(input logic [35:0] b, input logic [7:0] t);
      return {28'd0, b[35:12], 4'd0, t};
   endfunction
   function automatic logic [63:0] vmask(input int k, input bit v);
      logic [23:0] m = 24'hFFFFFF << k;
      return {28'd0, m, v, 11'd0};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] e_old;
      void'($urandom(32'h1F2E3D4C));
      rst = 1; wr_en = 0; wr_sel = 0; wr_idx = 0; wr_data = 0; lk_addr = 0;
      m_fix = 0; m_def = 0;
      for (int p = 0; p < 8; p++) begin m_base[p] = 0; m_mask[p] = 0; end
      repeat (3) @(negedge clk);
      rst = 0;

      // R1: reset state
      chk(36'h000000000, "R1");
      chk(36'h0000A8000, "R1");
      chk(36'hFFFFFFFFF, "R1");

      // R2: each slice gets its own field; slice k holds code 4 or 6
      wr(2'd1, 4'd0, 64'h06_04_06_04_04_06_06_04, 1);
      for (int k = 0; k < 8; k++) chk(36'h0A0000 + k * 36'h4000, "R2");
      chk(36'h0A3FFF, "R2");
      chk(36'h0A4000, "R2");
      chk(36'h0BFFFF, "R2");

      // R6: default type
      wr(2'd2, 4'd0, 64'h6, 1);
      chk(36'h0C0000, "R6");
      chk(36'h09FFFF, "R3");

      // R3: variable UC range covering whole low 1 MB does not beat fixed
      wr(2'd0, 4'd0, vbase(36'h0, 8'd0), 1);
      wr(2'd0, 4'd1, vmask(8, 1), 1);
      chk(36'h0A4000, "R3");
      chk(36'h0BFFFF, "R3");
      chk(36'h0C0000, "R3");
      chk(36'h09FFFF, "R3");

      // R4/R5: overlapping ranges WB(2MB) > WT(64KB) > UC(4KB) nested at 0x1000000
      wr(2'd0, 4'd1, vmask(0, 0), 1);
      wr(2'd0, 4'd2, vbase(36'h1000000, 8'd6), 1);
      wr(2'd0, 4'd3, vmask(9, 1), 1);
      wr(2'd0, 4'd4, vbase(36'h1000000, 8'd4), 1);
      wr(2'd0, 4'd5, vmask(4, 1), 1);
      wr(2'd0, 4'd14, vbase(36'h1000000, 8'd0), 1);
      wr(2'd0, 4'd15, vmask(0, 1), 1);
      chk(36'h1000800, "R5");     // UC wins
      chk(36'h1008000, "R5");     // WT over WB
      chk(36'h1100000, "R4");     // WB only
      chk(36'h1200000, "R4");     // outside mask -> default
      wr(2'd0, 4'd15, vmask(0, 0), 1);   // clear valid
      chk(36'h1000800, "R4");

      // R7: illegal codes become uncacheable
      wr(2'd0, 4'd4, vbase(36'h1000000, 8'd5), 1);
      chk(36'h1008000, "R7");
      wr(2'd1, 4'd0, 64'h0000_0000_0000_0207, 1);
      chk(36'h0A0000, "R7");
      chk(36'h0A4000, "R7");
      wr(2'd2, 4'd0, 64'h1, 1);
      chk(36'h3000000, "R7");

      // R8: spare target and dropped strobe change nothing
      wr(2'd3, 4'd0, 64'h0606060606060606, 1);
      chk(36'h0A8000, "R8");
      chk(36'h3000000, "R8");
      wr(2'd1, 4'd0, 64'h0606060606060606, 0);
      chk(36'h0A8000, "R8");
      wr(2'd0, 4'd3, vmask(9, 0), 0);
      chk(36'h1100000, "R8");

      // R9: output holds until the edge after the address changes
      chk(36'h1100000, "R9");
      e_old = model(36'h1100000);
      @(negedge clk);
      lk_addr = 36'h0A0000;
      #1;
      checks++;
      if (lk_type !== e_old) begin
         fails++;
         $display("FAIL R9 early actual=%0d expected=%0d", lk_type, e_old);
      end
      @(negedge clk);
      checks++;
      if (lk_type !== model(36'h0A0000)) begin
         fails++;
         $display("FAIL R9 late actual=%0d expected=%0d", lk_type, model(36'h0A0000));
      end

      // Random mix: R2 R3 R4 R5 R6 R7
      for (int n = 0; n < 400; n++) begin
         int unsigned r = $urandom_range(0, 9);
         if (r < 3) begin
            logic [7:0] codes[4] = '{8'd0, 8'd4, 8'd6, 8'd3};
            logic [3:0] ix = 4'($urandom_range(0, 15));
            if (ix[0])
               wr(2'd0, ix, vmask($urandom_range(0, 12), ($urandom_range(0, 3) != 0)), 1);
            else
               wr(2'd0, ix, vbase({12'd0, 4'($urandom_range(0, 3)), 8'($urandom), 12'd0},
                                  codes[$urandom_range(0, 3)]), 1);
         end else if (r == 3) begin
            wr(2'($urandom_range(1, 3)), 4'd0, {$urandom, $urandom}, ($urandom_range(0, 1) == 1));
         end else begin
            logic [35:0] a;
            int unsigned q = $urandom_range(0, 2);
            if (q == 0) a = 36'h0A0000 + 36'($urandom_range(0, 36'h1FFFF));
            else if (q == 1) a = {m_base[$urandom_range(0, 7)][35:12], 12'd0}
                                 ^ 36'($urandom_range(0, 36'h3FFFF));
            else a = {4'd0, $urandom};
            chk(a, "R5");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule